// File: doc/BRIEF.md
# SDRAM Command Sequencer with Periodic Refresh

This block sits between a simple request port and a single-rank, four-bank SDRAM clocked at 100 MHz. After reset it raises the clock enable, closes every bank and loads the mode register with the burst length and CAS latency chosen by parameters. It then serves one request at a time. Each request names a bank, a 12-bit row and a 9-bit column. The block opens the row and issues the read or write with auto-precharge, so the row closes again without a separate precharge command.

All command spacing is counted in clocks for a 10 ns period. A refresh timer raises a request every `REF_INTERVAL` clocks. Because every access leaves all banks closed, the pending refresh is issued as soon as the current access has run its course, ahead of any waiting user request.

For the data path, the block raises `wr_beat` on the clocks where write data must be on the bus. It raises `rd_valid` on the clocks where read data returns, CAS-latency clocks after the read command. It drives DQM so that the device's data pins are enabled only around those beats.

Top module: `sdram_seq`

## Requirements
- R1: While `rst` is high the block drives a deselect (chip select high), CKE low, all DQM bits high, and keeps `wr_beat` and `rd_valid` low. CKE is high by the time of the first command.
- R2: The first command after reset is a precharge with A10 high, which closes all banks. The mode-register load follows exactly 2 clocks later.
- R3: The mode-register load carries bank 0 and the following address fields, with all other address bits 0:
  - A2..A0 hold the burst-length code: 1→0, 2→1, 4→2, 8→3.
  - A3 is 0, selecting a sequential burst.
  - A6..A4 hold the CAS latency.
  
  The next command after the load comes no earlier than 2 clocks after it.
- R4: Commands on {CS#, RAS#, CAS#, WE#` are encoded as follows: mode load 0000, refresh 0001, precharge 0010, activate 0011, write 0100, read 0101, no-op 0111. An activate carries the request's bank on BA and its row on A11..A0, and requests are served in arrival order.
- R5: The read or write comes exactly 2 clocks after its activate. It carries the same bank, the column on A8..A0 and A10 high (auto-precharge), with the other address bits low.
- R6: The next command after a column command to activate clock a and column clock c comes no earlier than the latest of three clocks: a+7, max(a+5, c+BL)+2, and, for reads only, c+CL+BL. When a request is waiting, it comes at exactly that clock.
- R7: `wr_beat` is high in the clock of a write command and in the BL−1 clocks after it, and low otherwise.
- R8: `rd_valid` is high for BL clocks starting CL clocks after a read command, and low otherwise.
- R9: All DQM bits are low during write beats and during the BL clocks starting CL−2 clocks after a read command. They are high at every other time.
- R10: A refresh is requested every `REF_INTERVAL` clocks and issued as an auto-refresh command. The next command comes no earlier than 7 clocks after it, and exactly then when a request is waiting.
- R11: A pending refresh is issued before any further activate. Consecutive refreshes are therefore spaced within `REF_INTERVAL` ± 10 clocks, even under continuous traffic.
- R12: `req_ready` is high only while the block is idle with no refresh pending. A request accepted on a clock edge appears as an activate in the very next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 100 MHz |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_row | input | 12 | Row address |
| req_col | input | 9 | Column address |
| wr_beat | output | 1 | Write data must be driven in this clock |
| rd_valid | output | 1 | Read data is returned in this clock |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Multiplexed address |
| sd_dqm | output | 8 | Data mask / output enable, one bit per byte lane |

## Verification
The assertions take for granted that request fields stay stable while `req_valid` is high and `req_ready` is low. They also assume that only one access is ever open, which the block guarantees itself by serving requests one at a time. The refresh check assumes that no access lasts anywhere near a refresh interval, which holds for every legal burst length and CAS latency.

The bench keeps `req_valid` high with a fresh request after each acceptance. This makes every command slot deterministic, so the spacing can be checked to the exact clock. It sweeps all banks, both directions and spread rows and columns long enough to cross several refresh periods.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    parameter int ROW_W  = 12;
    parameter int COL_W  = 9;
    parameter int BANK_W = 2;
    parameter int AP_BIT = 10;

    // clock counts for a 10 ns period
    parameter int T_RCD = 2;
    parameter int T_RP  = 2;
    parameter int T_RAS = 5;
    parameter int T_RC  = 7;
    parameter int T_RFC = 7;
    parameter int T_MRD = 2;

    typedef enum logic [3:0] {
        CMD_MRS   = 4'b0000,
        CMD_REF   = 4'b0001,
        CMD_PRE   = 4'b0010,
        CMD_ACT   = 4'b0011,
        CMD_WR    = 4'b0100,
        CMD_RD    = 4'b0101,
        CMD_NOP   = 4'b0111,
        CMD_DESEL = 4'b1111
    } cmd_e;

    typedef enum logic [2:0] {
        ST_PREALL,
        ST_LOADMODE,
        ST_IDLE,
        ST_COLUMN,
        ST_HOLD
    } state_e;

    typedef struct packed {
        logic              write;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } req_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [ROW_W-1:0] mode_word(input int bl, input int cl);
        logic [ROW_W-1:0] w;
        w      = '0;
        w[2:0] = 3'($clog2(bl));
        w[6:4] = 3'(cl);
        return w;
    endfunction

    function automatic logic [ROW_W-1:0] col_word(input logic [COL_W-1:0] c);
        logic [ROW_W-1:0] w;
        w              = '0;
        w[COL_W-1:0]   = c;
        w[AP_BIT]      = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int INTERVAL = 1562
) (
    input  logic clk,
    input  logic rst,
    input  logic ack,
    output logic pend
);
    localparam int CW = $clog2(INTERVAL);

    logic [CW-1:0] cnt;
    logic          expire;

    assign expire = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= CW'(INTERVAL - 1);
            pend <= 1'b0;
        end else begin
            cnt  <= expire ? CW'(INTERVAL - 1) : cnt - 1'b1;
            pend <= (pend & ~ack) | expire;
        end
    end

    // R11
    ref_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        expire |-> !pend);

endmodule

// File: rtl/sdram_data_window.sv
module sdram_data_window #(
    parameter int BURST_LEN = 4,
    parameter int CAS_LAT   = 3,
    parameter int DQM_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             start_wr,
    output logic             wr_beat,
    output logic             rd_valid,
    output logic [DQM_W-1:0] dqm
);
    localparam int SPAN = CAS_LAT + BURST_LEN;
    localparam int CW   = $clog2(SPAN + 1);

    logic [CW-1:0] cnt;
    logic          live;
    logic          is_wr;
    logic          drv_en;
    int            k;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            live  <= 1'b0;
            is_wr <= 1'b0;
        end else if (start) begin
            cnt   <= '0;
            live  <= 1'b1;
            is_wr <= start_wr;
        end else if (live) begin
            if (cnt == CW'(SPAN - 1)) live <= 1'b0;
            else                      cnt  <= cnt + 1'b1;
        end
    end

    always_comb begin
        k        = int'(cnt);
        wr_beat  = live && is_wr && (k < BURST_LEN);
        rd_valid = live && !is_wr && (k >= CAS_LAT) && (k < SPAN);
        drv_en   = wr_beat || (live && !is_wr && (k >= CAS_LAT - 2) && (k < SPAN - 2));
        dqm      = {DQM_W{~drv_en}};
    end

    // R9
    rd_dqm_lead_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(dqm, 2) == '0));

endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
    import sdram_seq_pkg::*;
#(
    parameter int BURST_LEN    = 4,
    parameter int CAS_LAT      = 3,
    parameter int REF_INTERVAL = 1562,
    parameter int DQM_W        = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic              wr_beat,
    output logic              rd_valid,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [DQM_W-1:0]  sd_dqm
);
    localparam int GAP_WR = max2(T_RC - T_RCD, max2(T_RAS - T_RCD, BURST_LEN) + T_RP);
    localparam int GAP_RD = max2(GAP_WR, CAS_LAT + BURST_LEN);
    localparam int WCW    = $clog2(GAP_RD + T_RFC + 1);
    localparam logic [ROW_W-1:0] MODE = mode_word(BURST_LEN, CAS_LAT);

    state_e            state, after;
    logic [WCW-1:0]    wcnt;
    cmd_e              cmd_q;
    logic [BANK_W-1:0] ba_q;
    logic [ROW_W-1:0]  addr_q;
    logic              cke_q;
    req_t              held;
    logic              ref_pend;
    logic              ref_ack;

    assign ref_ack   = (state == ST_IDLE) && ref_pend;
    assign req_ready = (state == ST_IDLE) && !ref_pend;

    sdram_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_refresh (
        .clk  (clk),
        .rst  (rst),
        .ack  (ref_ack),
        .pend (ref_pend)
    );

    sdram_data_window #(.BURST_LEN(BURST_LEN), .CAS_LAT(CAS_LAT), .DQM_W(DQM_W)) u_window (
        .clk      (clk),
        .rst      (rst),
        .start    (state == ST_COLUMN),
        .start_wr (held.write),
        .wr_beat  (wr_beat),
        .rd_valid (rd_valid),
        .dqm      (sd_dqm)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_PREALL;
            after  <= ST_IDLE;
            wcnt   <= '0;
            cmd_q  <= CMD_DESEL;
            ba_q   <= '0;
            addr_q <= '0;
            cke_q  <= 1'b0;
            held   <= '0;
        end else begin
            cke_q <= 1'b1;
            cmd_q <= CMD_NOP;
            unique case (state)
                ST_PREALL: if (cke_q) begin
                    cmd_q          <= CMD_PRE;
                    addr_q         <= '0;
                    addr_q[AP_BIT] <= 1'b1;
                    wcnt           <= WCW'(T_RP - 2);
                    after          <= ST_LOADMODE;
                    state          <= ST_HOLD;
                end
                ST_LOADMODE: begin
                    cmd_q  <= CMD_MRS;
                    ba_q   <= '0;
                    addr_q <= MODE;
                    wcnt   <= WCW'(T_MRD - 2);
                    after  <= ST_IDLE;
                    state  <= ST_HOLD;
                end
                ST_IDLE: begin
                    if (ref_pend) begin
                        cmd_q <= CMD_REF;
                        wcnt  <= WCW'(T_RFC - 2);
                        after <= ST_IDLE;
                        state <= ST_HOLD;
                    end else if (req_valid) begin
                        cmd_q  <= CMD_ACT;
                        ba_q   <= req_bank;
                        addr_q <= req_row;
                        held   <= '{write: req_write, bank: req_bank, row: req_row, col: req_col};
                        wcnt   <= WCW'(T_RCD - 2);
                        after  <= ST_COLUMN;
                        state  <= ST_HOLD;
                    end
                end
                ST_COLUMN: begin
                    cmd_q  <= held.write ? CMD_WR : CMD_RD;
                    ba_q   <= held.bank;
                    addr_q <= col_word(held.col);
                    wcnt   <= held.write ? WCW'(GAP_WR - 2) : WCW'(GAP_RD - 2);
                    after  <= ST_IDLE;
                    state  <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (wcnt == '0) state <= after;
                    else            wcnt  <= wcnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
    assign sd_cke  = cke_q;
    assign sd_ba   = ba_q;
    assign sd_addr = addr_q;

    // activate-to-activate distance, observed on the command outputs
    localparam int SAW = $clog2(T_RC + 1);
    logic [SAW-1:0] since_act;
    logic           seen_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_act <= '0;
            seen_act  <= 1'b0;
        end else if (cmd_q == CMD_ACT) begin
            since_act <= SAW'(1);
            seen_act  <= 1'b1;
        end else if (int'(since_act) < T_RC) begin
            since_act <= since_act + 1'b1;
        end
    end

    // R6
    act_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_ACT && seen_act) |-> (int'(since_act) >= T_RC));

    // R5
    act_to_col_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> ($past(cmd_q, T_RCD) == CMD_ACT));

    // R5
    col_autopre_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> sd_addr[AP_BIT]);

    // R3
    mrs_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_MRS) |=> (cmd_q == CMD_NOP));

endmodule

// File: tb/tb_sdram_seq.sv
module tb_sdram_seq;
    import sdram_seq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int BL    = 4;
    localparam int CL    = 3;
    localparam int RI    = 1562;
    localparam int DQW   = 8;
    localparam int NREQ  = 480;
    localparam int LIMIT = 20000;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid, req_ready, req_write;
    logic [BANK_W-1:0] req_bank;
    logic [ROW_W-1:0]  req_row;
    logic [COL_W-1:0]  req_col;
    logic              wr_beat, rd_valid, sd_cke;
    logic              sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [BANK_W-1:0] sd_ba;
    logic [ROW_W-1:0]  sd_addr;
    logic [DQW-1:0]    sd_dqm;

    sdram_seq #(.BURST_LEN(BL), .CAS_LAT(CL), .REF_INTERVAL(RI), .DQM_W(DQW)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .wr_beat(wr_beat), .rd_valid(rd_valid), .sd_cke(sd_cke),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int f_bank(input int i);  return i % 4; endfunction
    function automatic int f_wr(input int i);    return (i / 4) % 2; endfunction
    function automatic int f_row(input int i);   return (i * 613 + i / 8) % 4096; endfunction
    function automatic int f_col(input int i);   return (i * 29 + 3) % 512; endfunction

    function automatic int imax(input int a, input int b); return (a > b) ? a : b; endfunction

    initial begin
        int  cyc, idx, act_idx, act_cyc, cas_cyc, cas_wr, nxt, pre_cyc, mrs_cyc, last_ref, ref_cnt;
        bit  took, prev_took, done;
        logic [3:0] cmd;
        int  k, ewr, erd, eon, exp_mode;

        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0;
        req_bank = '0; req_row = '0; req_col = '0;
        repeat (5) begin
            @(negedge clk);
            // R1 reset outputs
            chk(sd_cs_n == 1'b1, "R1", "cs_n in reset", int'(sd_cs_n), 1);
            chk(sd_cke == 1'b0, "R1", "cke in reset", int'(sd_cke), 0);
            chk(!wr_beat && !rd_valid, "R1", "data flags in reset", int'(wr_beat) + int'(rd_valid), 0);
            chk(sd_dqm == '1, "R1", "dqm in reset", int'(sd_dqm), 255);
        end
        rst = 1'b0;
        req_valid = 1'b1;
        req_write = 1'(f_wr(0)); req_bank = BANK_W'(f_bank(0));
        req_row = ROW_W'(f_row(0)); req_col = COL_W'(f_col(0));

        cyc = 0; idx = 0; act_idx = 0; act_cyc = -100; cas_cyc = -1; cas_wr = 0;
        nxt = 0; pre_cyc = -1; mrs_cyc = -1; last_ref = -1; ref_cnt = 0;
        took = 0; prev_took = 0; done = 0;
        exp_mode = (CL << 4) | $clog2(BL);

        while (!done && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
            prev_took = took;
            if (took) idx++;
            cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

            // R12 accepted request shows as activate next clock
            if (prev_took)
                chk(cmd == CMD_ACT, "R12", "activate after accept", int'(cmd), int'(CMD_ACT));

            case (cmd)
                CMD_PRE: begin
                    chk(pre_cyc < 0 && mrs_cyc < 0, "R2", "precharge only at init", cyc, pre_cyc);
                    chk(sd_addr[AP_BIT] == 1'b1, "R2", "precharge-all A10", int'(sd_addr[AP_BIT]), 1);
                    chk(sd_cke == 1'b1, "R1", "cke at first command", int'(sd_cke), 1);
                    pre_cyc = cyc;
                end
                CMD_MRS: begin
                    chk(pre_cyc >= 0 && cyc - pre_cyc == 2, "R2", "precharge to mode load", cyc - pre_cyc, 2);
                    chk(int'(sd_addr) == exp_mode, "R3", "mode word", int'(sd_addr), exp_mode);
                    chk(sd_ba == '0, "R3", "mode bank", int'(sd_ba), 0);
                    mrs_cyc = cyc;
                    nxt = cyc + 2;
                end
                CMD_ACT: begin
                    chk(mrs_cyc >= 0 && cyc == nxt, "R6", "activate slot", cyc, nxt);
                    chk(act_idx < NREQ, "R4", "activate count", act_idx, NREQ);
                    chk(int'(sd_ba) == f_bank(act_idx), "R4", "activate bank", int'(sd_ba), f_bank(act_idx));
                    chk(int'(sd_addr) == f_row(act_idx), "R4", "activate row", int'(sd_addr), f_row(act_idx));
                    act_cyc = cyc;
                    act_idx++;
                end
                CMD_WR, CMD_RD: begin
                    chk(cyc - act_cyc == 2, "R5", "activate to column", cyc - act_cyc, 2);
                    chk(int'(cmd == CMD_WR) == f_wr(act_idx - 1), "R4", "direction", int'(cmd), f_wr(act_idx - 1));
                    chk(int'(sd_ba) == f_bank(act_idx - 1), "R5", "column bank", int'(sd_ba), f_bank(act_idx - 1));
                    chk(int'(sd_addr) == (f_col(act_idx - 1) | 1024), "R5", "column word with A10",
                        int'(sd_addr), f_col(act_idx - 1) | 1024);
                    cas_cyc = cyc;
                    cas_wr = (cmd == CMD_WR) ? 1 : 0;
                    nxt = imax(act_cyc + 7, imax(act_cyc + 5, cyc + BL) + 2);
                    if (!cas_wr) nxt = imax(nxt, cyc + CL + BL);
                end
                CMD_REF: begin
                    chk(mrs_cyc >= 0 && cyc >= nxt, "R10", "refresh slot", cyc, nxt);
                    if (idx < NREQ)
                        chk(cyc == nxt, "R11", "refresh takes first free slot", cyc, nxt);
                    if (last_ref < 0)
                        chk(cyc <= RI + 12, "R11", "first refresh time", cyc, RI);
                    else
                        chk(cyc - last_ref >= RI - 10 && cyc - last_ref <= RI + 10,
                            "R11", "refresh spacing", cyc - last_ref, RI);
                    last_ref = cyc;
                    ref_cnt++;
                    nxt = cyc + 7; // R10
                end
                CMD_NOP, CMD_DESEL: ;
                default: chk(1'b0, "R4", "illegal command", int'(cmd), int'(CMD_NOP));
            endcase

            // R7 R8 R9 data window
            ewr = 0; erd = 0; eon = 0;
            if (cas_cyc >= 0) begin
                k   = cyc - cas_cyc;
                ewr = (cas_wr == 1 && k < BL) ? 1 : 0;
                erd = (cas_wr == 0 && k >= CL && k < CL + BL) ? 1 : 0;
                eon = (ewr == 1 || (cas_wr == 0 && k >= CL - 2 && k < CL + BL - 2)) ? 1 : 0;
            end
            chk(int'(wr_beat) == ewr, "R7", "write beat", int'(wr_beat), ewr);
            chk(int'(rd_valid) == erd, "R8", "read valid", int'(rd_valid), erd);
            chk(sd_dqm == {DQW{eon == 0}}, "R9", "dqm", int'(sd_dqm), (eon == 0) ? 255 : 0);

            // drive next request
            if (idx < NREQ) begin
                req_valid = 1'b1;
                req_write = 1'(f_wr(idx));
                req_bank  = BANK_W'(f_bank(idx));
                req_row   = ROW_W'(f_row(idx));
                req_col   = COL_W'(f_col(idx));
            end else begin
                req_valid = 1'b0;
            end
            took = req_valid && req_ready;

            if (act_idx == NREQ && cyc >= nxt + 2) done = 1;
        end

        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion before %0d", cyc, LIMIT);
        end else begin
            // R10 several refresh periods crossed
            chk(ref_cnt >= 2, "R10", "refresh count", ref_cnt, 2);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule